// File: doc/BRIEF.md
# Stripe-Scan Coefficient Register Bank

This block sits between a wavelet stage and the bit-plane classification logic of an embedded block coder. Upstream hands it one code-block column of a four-row stripe at a time. Each entry is an 11-bit coefficient with a 1-bit flag for the pass of its most significant plane. The block keeps a 5-row by 4-column array of these 12-bit entries. On every accepted step it rotates each column by one place, so that three fixed register rows always carry the rows above, at and below the current centre. After four steps the columns move one place older and a new column enters.

Two 3x3 neighbourhood windows are presented, offset by one column. The first feeds the most-significant-plane classifier. The second, centred one column older, feeds the per-plane pass classifier. The row above a stripe comes from a 64-entry single-port line buffer, which holds the bottom row of the previous stripe. The row below the last row of a stripe is forced to zero (vertically causal coding). Neighbour columns that lie outside the block are forced to zero, and so is the top row of the first stripe of every block.

A `step` input advances the scan, and holding it low freezes the bank so that the consumer can stall.

Top module: `stripe_scan_bank`

## Requirements
- R1: While reset is held and just after it, every entry of both windows is zero, `first_col` is 1, `cen_row` is 0 and `col_take` is 0.
- R2: Each cycle with `step` high moves the centre row on by one (0,1,2,3,0...). `cen_row` gives the centre row, and `first_col` is high exactly when the centre row is 0.
- R3: `col_take` is high on the fourth step of a column (`step` high while `cen_row` is 3). In that cycle `col_in` is loaded as the newest column. Row r of the column sits at bits [12r+11:12r], and each entry is {flag at bit 11, coefficient at bits 10:0}.
- R4: Window entry (j,i) sits at bits [12(3j+i)+11 : 12(3j+i)]. Here j=0 is the newer (right) neighbour column, j=1 the centre column and j=2 the older (left) column. Row i=0 is above the centre, i=1 is the centre and i=2 is below. After the n-th load, window A is centred on the column loaded (n-1)th, one column older than the newest.
- R5: Window B has the same layout as window A, centred one column older again. Its centre column equals window A's left column whenever that column is not masked.
- R6: When the centre row is 0, the above entry of a column shows row 3 of the same column of the previous stripe, taken from the line buffer. In the first stripe of a block it shows zero.
- R7: When the centre row is 3, every below entry of both windows is zero.
- R8: When a window centre is block column 63, its right column is zero. When a window centre is block column 0, its left column is zero.
- R9: While `step` is low, both windows, `cen_row` and `first_col` hold their values.
- R10: After 16 stripes of 64 columns, the next column is column 0 of the first stripe of a new block. Its above entries are zero again, even though the line buffer still holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Advance the scan by one coefficient |
| col_in | input | 48 | Next column, four 12-bit entries, row 0 in the low bits |
| col_take | output | 1 | `col_in` is loaded at this clock edge |
| first_col | output | 1 | Window centres are the first row of their column |
| cen_row | output | 2 | Row of the window centres within the stripe |
| win_a | output | 108 | Nine-entry window for the MSB-plane classifier |
| win_b | output | 108 | Nine-entry window, one column older, for the pass classifier |

## Verification
The assertions assume that `col_in` carries the right column whenever `col_take` is high, and that columns arrive in stripe order with no gaps. The bench always presents the column whose number equals the count of columns already loaded, so this holds. The assertions also assume that `step` is the only thing that advances the bank. The bench changes `step` only between edges, including runs of stalled cycles. It runs past a full block so that the wrap of the stripe count is exercised.

// File: rtl/stripe_scan_bank.sv
module stripe_scan_bank #(
  parameter int CW = 11,
  parameter int BW = 64,
  parameter int STRIPES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  input  logic [4*(CW+1)-1:0]   col_in,
  output logic                  col_take,
  output logic                  first_col,
  output logic [1:0]            cen_row,
  output logic [9*(CW+1)-1:0]   win_a,
  output logic [9*(CW+1)-1:0]   win_b
);
  localparam int EW = CW + 1;
  localparam int AW = $clog2(BW);
  localparam int SW = (STRIPES > 1) ? $clog2(STRIPES) : 1;
  localparam logic [AW-1:0] LASTC = AW'(BW - 1);
  localparam logic [SW-1:0] LASTS = SW'(STRIPES - 1);

  function automatic logic [AW-1:0] wsub(input logic [AW-1:0] x, input int unsigned k);
    int unsigned t;
    t = int'(x) + BW - k;
    return AW'(t % BW);
  endfunction

  logic [EW-1:0] arr [4][5];
  logic [EW-1:0] lb_mem [BW];
  logic [EW-1:0] lb_q;
  logic [1:0]    phase;
  logic [AW-1:0] load_col;
  logic [SW-1:0] load_stripe;

  logic          shift;
  logic [AW-1:0] nxt_col, out_col, a_cen, b_cen;
  logic [SW-1:0] nxt_stripe;
  logic [2:0]    mask_a, mask_b;

  assign shift      = step && (phase == 2'd3);
  assign nxt_col    = (load_col == LASTC) ? '0 : load_col + 1'b1;
  assign nxt_stripe = (load_col != LASTC) ? load_stripe :
                      (load_stripe == LASTS) ? '0 : load_stripe + 1'b1;
  assign out_col    = wsub(load_col, 3);
  assign a_cen      = wsub(load_col, 1);
  assign b_cen      = wsub(load_col, 2);
  assign mask_a     = {a_cen == '0, 1'b0, a_cen == LASTC};
  assign mask_b     = {b_cen == '0, 1'b0, b_cen == LASTC};

  assign col_take   = shift;
  assign first_col  = (phase == 2'd0);
  assign cen_row    = phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= '0;
      load_col    <= LASTC;
      load_stripe <= LASTS;
    end else if (step) begin
      phase <= phase + 1'b1;
      if (shift) begin
        load_col    <= nxt_col;
        load_stripe <= nxt_stripe;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 5; p++)
          arr[c][p] <= '0;
    end else if (step) begin
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 5; p++)
          if (!shift)
            arr[c][p] <= arr[c][(p + 1) % 5];
          else if (c == 0)
            arr[c][p] <= (p == 0) ? lb_q : col_in[(p - 1) * EW +: EW];
          else
            arr[c][p] <= arr[c - 1][(p + 2) % 5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      lb_q <= '0;
    else if (step && phase == 2'd2)
      lb_q <= (nxt_stripe == '0) ? '0 : lb_mem[nxt_col];
  end

  always_ff @(posedge clk) begin
    if (shift)
      lb_mem[out_col] <= arr[3][1];
  end

  for (genvar j = 0; j < 3; j++) begin : g_col
    for (genvar i = 0; i < 3; i++) begin : g_row
      assign win_a[EW*(3*j+i) +: EW] =
        (mask_a[j] || (i == 2 && phase == 2'd3)) ? '0 : arr[j][i];
      assign win_b[EW*(3*j+i) +: EW] =
        (mask_b[j] || (i == 2 && phase == 2'd3)) ? '0 : arr[j+1][i];
    end
  end

  // R2
  rot_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase != 2'd3) |=> win_a[EW*4 +: EW] == $past(win_a[EW*5 +: EW]));

  // R2
  rot_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && phase != 2'd3) |=> win_a[EW*3 +: EW] == $past(win_a[EW*4 +: EW]));

  // R3
  load_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && load_col != LASTC) |=> win_a[EW*1 +: EW] == $past(col_in[0 +: EW]));

  // R5
  win_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cen != '0) |-> win_b[EW*3 +: 3*EW] == win_a[EW*6 +: 3*EW]);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(win_a) && $stable(win_b) && $stable(cen_row));
endmodule

// File: tb/stripe_scan_bank_test.sv
module stripe_scan_bank_test;
  localparam int EW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic [4*EW-1:0] col_in = '0;
  logic col_take, first_col;
  logic [1:0] cen_row;
  logic [9*EW-1:0] win_a, win_b;

  stripe_scan_bank uut (
    .clk(clk), .rst_n(rst_n), .step(step), .col_in(col_in),
    .col_take(col_take), .first_col(first_col), .cen_row(cen_row),
    .win_a(win_a), .win_b(win_b)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int n = 0;
  int k = 0;
  bit done = 0;

  localparam int NSEG = 8;
  localparam int SEG [NSEG][2] = '{
    '{1, 1}, '{5, 0}, '{300, 1}, '{9, 0}, '{1900, 1}, '{3, 0}, '{2300, 1}, '{130, 1}
  };

  function automatic logic [EW-1:0] coef(int g, int r);
    int idx;
    logic [10:0] code;
    idx = g * 4 + r;
    code = 11'(idx * 37 + 5);
    return {1'(((idx >> 2) ^ (idx >> 5)) & 1), code};
  endfunction

  function automatic logic [EW-1:0] ent(int g, int rr);
    if (g < 0 || rr > 3) return '0;
    if (rr < 0) begin
      if ((g / 64) % 16 == 0) return '0;
      return coef(g - 64, 3);
    end
    return coef(g, rr);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h (col %0d phase %0d)", tag, act, exp, n, k);
    end
  endtask

  task automatic check_win(input int c, input logic [9*EW-1:0] act, input bit isb);
    for (int j = 0; j < 3; j++) begin
      for (int i = 0; i < 3; i++) begin
        int g, rr, cc;
        logic [EW-1:0] e;
        string tag;
        g  = c + 1 - j;
        rr = k - 1 + i;
        cc = ((c % 64) + 64) % 64;
        if ((j == 0 && cc == 63) || (j == 2 && cc == 0)) begin
          e = '0; tag = "R8";
        end else if (rr > 3) begin
          e = '0; tag = "R7";
        end else if (rr < 0) begin
          e = ent(g, rr);
          tag = (g >= 1024 && (g / 64) % 16 == 0) ? "R10" : "R6";
        end else begin
          e = ent(g, rr);
          tag = isb ? "R5" : "R4";
        end
        chk(act[EW*(3*j+i) +: EW] === e, tag, act[EW*(3*j+i) +: EW], e);
      end
    end
  endtask

  task automatic check_all();
    check_win(n - 2, win_a, 1'b0);
    check_win(n - 3, win_b, 1'b1);
    chk(cen_row == 2'(k), "R2", EW'(cen_row), EW'(k));
    chk(first_col == (k == 0), "R2", EW'(first_col), EW'(k == 0));
  endtask

  function automatic logic [4*EW-1:0] pack(int g);
    logic [4*EW-1:0] v;
    for (int r = 0; r < 4; r++) v[EW*r +: EW] = coef(g, r);
    return v;
  endfunction

  task automatic cyc(input logic s);
    logic [9*EW-1:0] pa, pb;
    check_all();
    pa = win_a; pb = win_b;
    step = s;
    col_in = pack(n);
    #1;
    chk(col_take == (s && k == 3), "R3", EW'(col_take), EW'(s && k == 3));
    @(posedge clk);
    if (s) begin
      if (k == 3) n++;
      k = (k + 1) % 4;
    end
    @(negedge clk);
    if (!s) begin
      chk(win_a === pa, "R9", win_a[EW-1:0], pa[EW-1:0]);
      chk(win_b === pb, "R9", win_b[EW-1:0], pb[EW-1:0]);
    end
  endtask

  task automatic check_reset();
    chk(win_a === '0, "R1", win_a[EW-1:0], '0);
    chk(win_b === '0, "R1", win_b[EW-1:0], '0);
    chk(first_col === 1'b1, "R1", EW'(first_col), 12'd1);
    chk(cen_row === 2'd0, "R1", EW'(cen_row), 12'd0);
    chk(col_take === 1'b0, "R1", EW'(col_take), 12'd0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    n = 0; k = 0;
    for (int s = 0; s < NSEG; s++)
      for (int c = 0; c < SEG[s][0]; c++)
        cyc(SEG[s][1] != 0);

    rst_n = 1'b0;
    step = 1'b1;
    @(posedge clk);
    @(negedge clk);
    step = 1'b0;
    check_reset();
    rst_n = 1'b1;
    n = 0; k = 0;
    for (int c = 0; c < 24; c++) cyc(1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule